// File: doc/BRIEF.md
# Packed Lane Saturating Adder

This block adds or subtracts two 64-bit operands as a set of independent integer lanes. Each operation picks one of three lane widths: eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. The carry chain is cut at every lane boundary, so a lane that overflows never disturbs its neighbour. Each lane result is then wrapped, meaning only the low bits are kept, or clipped to the signed or unsigned limit of the lane. This suits audio and pixel data, where a clipped peak is far less harmful than a wrapped one.

One operation is accepted on every cycle that `in_valid` is high. The result is captured in an output register and shown one cycle later with `out_valid`. The block has no ready signal and applies no back-pressure. The consumer must take each result in the cycle it appears, because the next accepted operation overwrites it. Clipping is provided for 8-bit and 16-bit lanes only. The 32-bit lanes always wrap, and no single 64-bit add exists.

Top module: `simd_sat_adder`

## Requirements
- R1: `in_lane_sz` picks the lane width: 0 gives 8-bit lanes, 1 gives 16-bit lanes, and 2 or 3 gives 32-bit lanes. Lane k occupies bits [k*W +: W] of each operand and of the result.
- R2: No carry or borrow passes from one lane into the next. For example, 0xFF+0x01 in every 8-bit lane gives 0x00 in every lane, while 0x00FF+0x0001 in 16-bit lanes gives 0x0100.
- R3: `in_mode` 0 or 3 selects wraparound, which keeps only the low W bits of each lane result. For example, 8-bit 0x02+0xFF gives 0x01.
- R4: `in_mode` 2 selects unsigned clipping. An addition above the lane range gives all ones (0xFF or 0xFFFF).
- R5: With unsigned clipping, a subtraction whose result falls below zero gives 0.
- R6: `in_mode` 1 selects signed clipping, for both add and subtract. A result above the range gives 0x7F or 0x7FFF, and a result below the range gives 0x80 or 0x8000.
- R7: 32-bit lanes always wrap, whatever the value of `in_mode`.
- R8: `in_sub`=1 computes a−b in each lane, and `in_sub`=0 computes a+b.
- R9: `out_valid` equals `in_valid` delayed by one clock cycle. `out_data` loads only on a cycle with `in_valid` high and holds its value otherwise.
- R10: A synchronous active-high `rst` clears both `out_valid` and `out_data` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| in_a | input | 64 | First operand (minuend for subtract) |
| in_b | input | 64 | Second operand (subtrahend for subtract) |
| in_lane_sz | input | 2 | Lane width: 0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit |
| in_sub | input | 1 | 1 = subtract, 0 = add |
| in_mode | input | 2 | 0 or 3 = wrap, 1 = signed clip, 2 = unsigned clip |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_data | output | 64 | Registered packed result |

## Verification
Directed vectors place a carry or borrow at a lane edge so that a leaked carry shows up in the neighbouring lane. The same operands are then run through each mode, which separates wrap from signed and unsigned clipping in both directions and for both 8-bit and 16-bit lanes. Operands that would clip in a 32-bit lane show whether that width wraps as required, and lane-size code 3 is compared against code 2. A long run of pseudo-random operands across every width, mode and direction catches lane-slicing mistakes that the directed values miss. Idle gaps and a reset in the middle of the run confirm that the output holds between operations and is cleared by reset.

// File: rtl/simd_sat_pkg.sv
package simd_sat_pkg;

  typedef enum logic [1:0] {
    LANE_8   = 2'd0,
    LANE_16  = 2'd1,
    LANE_32  = 2'd2,
    LANE_32X = 2'd3
  } lane_sz_e;

  typedef enum logic [1:0] {
    CLIP_NONE     = 2'd0,
    CLIP_SIGNED   = 2'd1,
    CLIP_UNSIGNED = 2'd2,
    CLIP_NONE_ALT = 2'd3
  } clip_mode_e;

endpackage

// File: rtl/simd_sat_lane.sv
module simd_sat_lane
  import simd_sat_pkg::*;
#(
  parameter int W      = 8,
  parameter bit SAT_EN = 1'b1
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  clip_mode_e   mode_i,
  output logic [W-1:0] y_o
);
  localparam logic [W-1:0] ONES = '1;
  localparam logic [W-1:0] SMAX = ONES >> 1;
  localparam logic [W-1:0] SMIN = ~SMAX;

  logic [W-1:0] b_eff;
  logic [W-1:0] raw;
  logic         carry;
  logic         uns_ovf;
  logic         sgn_ovf;
  clip_mode_e   eff_mode;

  // Subtract is a + ~b + 1. The carry-in is local to this lane only.
  assign b_eff          = sub_i ? ~b_i : b_i;
  assign {carry, raw}   = {1'b0, a_i} + {1'b0, b_eff} + (W+1)'(sub_i);
  // Unsigned: a carry out on add, or no carry out (a borrow) on subtract.
  assign uns_ovf        = carry ^ sub_i;
  // Signed: the effective operands share a sign and the result does not.
  assign sgn_ovf        = (a_i[W-1] == b_eff[W-1]) && (raw[W-1] != a_i[W-1]);
  // Lanes too wide for clipping see a constant wrap mode.
  assign eff_mode       = SAT_EN ? mode_i : CLIP_NONE;

  always_comb begin
    y_o = raw;
    case (eff_mode)
      CLIP_SIGNED:   if (sgn_ovf) y_o = a_i[W-1] ? SMIN : SMAX;
      CLIP_UNSIGNED: if (uns_ovf) y_o = sub_i ? '0 : ONES;
      default:       y_o = raw;
    endcase
  end

endmodule

// File: rtl/simd_lane_group.sv
module simd_lane_group
  import simd_sat_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int LANE_W    = 8,
  parameter int MAX_SAT_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  input  clip_mode_e        mode_i,
  output logic [DATA_W-1:0] y_o
);
  localparam int N_LANES = DATA_W / LANE_W;
  localparam bit SAT_EN  = (LANE_W <= MAX_SAT_W);

  for (genvar k = 0; k < N_LANES; k++) begin : g_lane
    simd_sat_lane #(.W(LANE_W), .SAT_EN(SAT_EN)) u_lane (
      .a_i    (a_i[k*LANE_W +: LANE_W]),
      .b_i    (b_i[k*LANE_W +: LANE_W]),
      .sub_i  (sub_i),
      .mode_i (mode_i),
      .y_o    (y_o[k*LANE_W +: LANE_W])
    );
  end

endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder
  import simd_sat_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int MIN_LANE_W = 8,
  parameter int MAX_SAT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [1:0]        in_lane_sz,
  input  logic              in_sub,
  input  logic [1:0]        in_mode,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int W_S  = MIN_LANE_W;
  localparam int W_M  = 2 * MIN_LANE_W;
  localparam int W_L  = 4 * MIN_LANE_W;
  localparam int N_S  = DATA_W / W_S;
  localparam int N_M  = DATA_W / W_M;

  clip_mode_e        mode;
  lane_sz_e          lsz;
  logic [DATA_W-1:0] y_s, y_m, y_l;
  logic [DATA_W-1:0] nxt;

  assign mode = clip_mode_e'(in_mode);
  assign lsz  = lane_sz_e'(in_lane_sz);

  simd_lane_group #(.DATA_W(DATA_W), .LANE_W(W_S), .MAX_SAT_W(MAX_SAT_W)) u_grp_s (
    .a_i(in_a), .b_i(in_b), .sub_i(in_sub), .mode_i(mode), .y_o(y_s));
  simd_lane_group #(.DATA_W(DATA_W), .LANE_W(W_M), .MAX_SAT_W(MAX_SAT_W)) u_grp_m (
    .a_i(in_a), .b_i(in_b), .sub_i(in_sub), .mode_i(mode), .y_o(y_m));
  simd_lane_group #(.DATA_W(DATA_W), .LANE_W(W_L), .MAX_SAT_W(MAX_SAT_W)) u_grp_l (
    .a_i(in_a), .b_i(in_b), .sub_i(in_sub), .mode_i(mode), .y_o(y_l));

  always_comb begin
    case (lsz)
      LANE_8:  nxt = y_s;
      LANE_16: nxt = y_m;
      default: nxt = y_l;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= nxt;
    end
  end

  // R9: the strobe is delayed by one cycle, and the data holds while idle.
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r9_valid_drops: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));

  // R4, R5: an unsigned clipped lane never wraps past its first operand.
  for (genvar i = 0; i < N_S; i++) begin : g_chk_s
    a_r4_uns_add_no_wrap: assert property (@(posedge clk) disable iff (rst)
      (in_valid && lsz == LANE_8 && mode == CLIP_UNSIGNED && !in_sub)
      |-> (y_s[i*W_S +: W_S] >= in_a[i*W_S +: W_S]));
    a_r5_uns_sub_no_wrap: assert property (@(posedge clk) disable iff (rst)
      (in_valid && lsz == LANE_8 && mode == CLIP_UNSIGNED && in_sub)
      |-> (y_s[i*W_S +: W_S] <= in_a[i*W_S +: W_S]));
  end

  // R6: adding two non-negative values under signed clipping stays non-negative.
  for (genvar i = 0; i < N_M; i++) begin : g_chk_m
    a_r6_sgn_pos_stays_pos: assert property (@(posedge clk) disable iff (rst)
      (in_valid && lsz == LANE_16 && mode == CLIP_SIGNED && !in_sub &&
       !in_a[i*W_M + W_M-1] && !in_b[i*W_M + W_M-1])
      |-> !y_m[i*W_M + W_M-1]);
  end

endmodule

// File: tb/simd_sat_adder_tb.sv
`timescale 1ns/1ps
module simd_sat_adder_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_a = '0, in_b = '0;
  logic [1:0]  in_lane_sz = '0;
  logic        in_sub = 1'b0;
  logic [1:0]  in_mode = '0;
  logic        out_valid;
  logic [63:0] out_data;

  always #2.5 clk = ~clk;

  simd_sat_adder u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .in_lane_sz(in_lane_sz), .in_sub(in_sub), .in_mode(in_mode),
    .out_valid(out_valid), .out_data(out_data));

  typedef struct {
    logic [63:0] exp;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  int          n_checks = 0;
  int          n_fail   = 0;
  bit          done     = 1'b0;
  logic [63:0] last_exp = '0;
  logic [63:0] rng      = 64'h9E37_79B9_7F4A_7C15;

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model, written straight from the requirements.
  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic [1:0] sz, input logic sub,
                                        input logic [1:0] mode);
    int          w;
    logic [63:0] res;
    w   = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    res = '0;
    for (int k = 0; k < 64 / w; k++) begin
      longint mask, ua, ub, sa, sb, r, half;
      mask = (longint'(1) << w) - 1;
      half = longint'(1) << (w - 1);
      ua   = longint'((a >> (k * w))) & mask;
      ub   = longint'((b >> (k * w))) & mask;
      sa   = (ua >= half) ? ua - (mask + 1) : ua;
      sb   = (ub >= half) ? ub - (mask + 1) : ub;
      if (mode == 2'd2 && w <= 16) begin
        r = sub ? ua - ub : ua + ub;
        if (r > mask) r = mask;
        if (r < 0)    r = 0;
      end else if (mode == 2'd1 && w <= 16) begin
        r = sub ? sa - sb : sa + sb;
        if (r > half - 1) r = half - 1;
        if (r < -half)    r = -half;
      end else begin
        r = sub ? ua - ub : ua + ub;
      end
      res = res | ((64'(r) & 64'(mask)) << (k * w));
    end
    return res;
  endfunction

  task automatic send(input logic [63:0] a, input logic [63:0] b, input logic [1:0] sz,
                      input logic sub, input logic [1:0] mode, input string tag);
    item_t it;
    @(negedge clk);
    in_a = a; in_b = b; in_lane_sz = sz; in_sub = sub; in_mode = mode;
    in_valid = 1'b1;
    it.exp = model(a, b, sz, sub, mode);
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor: compare every result against the front of the scoreboard.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R9 unexpected out_valid", {63'd0, out_valid}, 64'd0);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        check(out_data === it.exp, it.tag, out_data, it.exp);
        last_exp = it.exp;
      end
    end
  end

  function automatic logic [63:0] xs(input logic [63:0] s);
    logic [63:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 7);
    t = t ^ (t << 17);
    return t;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: state held in reset
    check(out_valid === 1'b0 && out_data === 64'd0, "R10 reset state",
          {out_valid, out_data[62:0]}, 64'd0);
    rst = 1'b0;

    // R3: wrap drops the carry, 0x02 + 0xFF = 0x01 in each byte
    send({8{8'h02}}, {8{8'hFF}}, 2'd0, 1'b0, 2'd0, "R3 byte wrap 02+FF");
    // R2: no carry crosses lanes, but one stays within a wider lane
    send({8{8'hFF}}, {8{8'h01}}, 2'd0, 1'b0, 2'd0, "R2 byte lanes isolated");
    send({4{16'h00FF}}, {4{16'h0001}}, 2'd1, 1'b0, 2'd0, "R2 word internal carry");
    send({2{32'hFFFF_FFFF}}, {2{32'h0000_0001}}, 2'd2, 1'b0, 2'd0, "R2 dword lanes isolated");
    // R8: subtract in wrap mode
    send({8{8'h05}}, {8{8'h07}}, 2'd0, 1'b1, 2'd0, "R8 byte wrap 05-07");
    // R4: unsigned clip on add, mixed lanes
    send(64'h10F0_10F0_10F0_10F0, 64'h0020_0020_0020_0020, 2'd0, 1'b0, 2'd2, "R4 byte uns add");
    send({4{16'hFFF0}}, {4{16'h0100}}, 2'd1, 1'b0, 2'd2, "R4 word uns add");
    // R5: unsigned clip on subtract
    send({8{8'h10}}, {8{8'h20}}, 2'd0, 1'b1, 2'd2, "R5 byte uns sub");
    send({4{16'h0001}}, {4{16'hFFFF}}, 2'd1, 1'b1, 2'd2, "R5 word uns sub");
    // R6: signed clip, both directions and both widths
    send({8{8'h7F}}, {8{8'h01}}, 2'd0, 1'b0, 2'd1, "R6 byte sgn 7F+01");
    send({8{8'h80}}, {8{8'h01}}, 2'd0, 1'b1, 2'd1, "R6 byte sgn 80-01");
    send({8{8'h80}}, {8{8'hFF}}, 2'd0, 1'b0, 2'd1, "R6 byte sgn 80+FF");
    send({4{16'h7FFF}}, {4{16'h0001}}, 2'd1, 1'b0, 2'd1, "R6 word sgn 7FFF+1");
    send({4{16'h8000}}, {4{16'h0001}}, 2'd1, 1'b1, 2'd1, "R6 word sgn 8000-1");
    // R7: 32-bit lanes wrap in every mode
    send({2{32'h7FFF_FFFF}}, {2{32'h1}}, 2'd2, 1'b0, 2'd1, "R7 dword sgn wraps");
    send({2{32'hFFFF_FFFF}}, {2{32'h1}}, 2'd2, 1'b0, 2'd2, "R7 dword uns wraps");
    send({2{32'h0}}, {2{32'h1}}, 2'd2, 1'b1, 2'd2, "R7 dword uns sub wraps");
    // R1: size code 3 behaves as 32-bit lanes
    send({2{32'h0000_FFFF}}, {2{32'h0000_0001}}, 2'd3, 1'b0, 2'd2, "R1 size code 3");
    // R3: mode 3 wraps
    send({8{8'hF0}}, {8{8'h20}}, 2'd0, 1'b0, 2'd3, "R3 mode 3 wraps");
    idle(3);

    // R9: output holds and strobe low while idle
    check(out_valid === 1'b0 && out_data === last_exp, "R9 hold while idle", out_data, last_exp);

    // R1: pseudo-random sweep over sizes, modes and directions
    for (int i = 0; i < 64; i++) begin
      logic [63:0] ra, rb;
      rng = xs(rng); ra = rng;
      rng = xs(rng); rb = rng;
      send(ra, rb, rng[1:0], rng[2], rng[4:3], "R1 random sweep");
      if (rng[5]) idle(1);
    end
    idle(2);

    // R10: reset in mid-run clears the output
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0 && out_data === 64'd0, "R10 reset clears", out_data, 64'd0);
    rst = 1'b0;
    send({4{16'h1234}}, {4{16'h1111}}, 2'd1, 1'b1, 2'd0, "R8 word wrap sub after reset");
    idle(3);

    if (sb_q.size() != 0)
      check(1'b0, "R9 results missing", 64'(sb_q.size()), 64'd0);
    finish_run();
  end

endmodule